// File: doc/BRIEF.md
# Double-Buffered Input Capture Channel

This block is one input-capture channel of a timer. It uses two 16-bit registers. A holding register takes the selected count on every capture strobe. A result register, which software reads, is filled only from the holding register. The count comes from one of two free-running timer values, chosen by a select input. The capture strobe comes from an edge detector that runs on the same clock as the channel.

The result register is protected until it has been consumed. Once a value has moved into it, later strobes change only the holding register. A read strobe from software re-arms the move. On the next strobe the held value shifts into the result register, and the new count goes into the holding register in the same cycle.

After reset the channel needs two strobes before the result register holds a real capture. The first strobe fills the holding register. The second strobe makes the first shift and raises the valid flag.

Top module: `cap_dbuf_channel`

## Requirements
- R1: On each clock where `cap_evt` is high, `sub_val` takes the selected count one cycle later. With `cap_evt` low, `sub_val` holds even when the counts change.
- R2: `src_sel` = 0 selects `cnt_a` and `src_sel` = 1 selects `cnt_b`, as the value that is captured.
- R3: `main_val` is only ever loaded with the value `sub_val` held just before the load. It never takes the live count directly.
- R4: The first strobe after reset loads only `sub_val`. `main_val` stays 0 and `main_valid` stays 0.
- R5: The second strobe after reset moves the first capture into `main_val` and the second capture into `sub_val`, both in the same cycle.
- R6: After a shift, and with no read strobe since, further strobes update `sub_val` and leave `main_val` unchanged.
- R7: A `main_rd` pulse re-arms the transfer. The next strobe then shifts `sub_val` into `main_val`.
- R8: When `main_rd` and `cap_evt` are high in the same cycle, the read is taken first and that strobe shifts. Transfer is disarmed again afterwards, so the following strobe without a read does not shift.
- R9: After synchronous active-low reset, `main_val` = 0, `sub_val` = 0 and `main_valid` = 0.
- R10: `main_valid` goes to 1 one cycle after the first shift and stays 1 until reset.
- R11: A `main_rd` pulse with no strobe changes neither `main_val` nor `sub_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_a | input | 16 | First timer count |
| cnt_b | input | 16 | Second timer count |
| src_sel | input | 1 | Count source select: 0 = cnt_a, 1 = cnt_b |
| cap_evt | input | 1 | One-cycle capture strobe from the edge detector |
| main_rd | input | 1 | One-cycle strobe: software has read main_val |
| main_val | output | 16 | Result capture register |
| sub_val | output | 16 | Holding capture register |
| main_valid | output | 1 | Result register holds a real capture |

## Verification
The bench goes after the start-up sequence. A design that shifts on the first strobe would expose the zero held in the holding register, and would raise valid one capture early. It repeats strobes without a read: a design that overwrites the result register there loses the value software has not yet seen. It checks a lone read, which must not change either register, and it checks a read and a strobe in the same cycle. A design that gives the strobe priority in that cycle would miss the shift. A design that keeps transfer armed afterwards would shift again on the next strobe.

// File: rtl/cap_pkg.sv
// Package: types shared across the capture channel.
// Assumes: two count sources per channel.
package cap_pkg;
    typedef enum logic {
        SRC_A = 1'b0,
        SRC_B = 1'b1
    } cap_src_e;
endpackage

// File: rtl/cap_src_mux.sv
// Module: cap_src_mux
// Picks the count that the channel captures, from two timer values.
// Assumes: both counts are synchronous to the channel clock.
module cap_src_mux
    import cap_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt_a,
    input  logic [W-1:0] cnt_b,
    input  cap_src_e     sel,
    output logic [W-1:0] cnt_out
);
    // Combinational select of the count source.
    always_comb begin
        unique case (sel)
            SRC_A:   cnt_out = cnt_a;
            SRC_B:   cnt_out = cnt_b;
            default: cnt_out = cnt_a;
        endcase
    end
endmodule

// File: rtl/cap_xfer_ctl.sv
// Module: cap_xfer_ctl
// Decides when a strobe shifts the holding register into the result register.
// Tracks whether the holding register has been filled and whether software
// has consumed the current result. A read in the same cycle as a strobe
// counts first.
// Assumes: cap_evt and main_rd are single-cycle strobes on clk.
module cap_xfer_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_evt,
    input  logic main_rd,
    output logic do_load,
    output logic do_shift,
    output logic main_valid
);
    logic xfer_en;
    logic sub_loaded;
    logic armed;

    // A read in this cycle arms the transfer before the strobe is judged.
    assign armed    = xfer_en | main_rd;
    assign do_load  = cap_evt;
    assign do_shift = cap_evt & sub_loaded & armed;

    // Transfer-enable flag: cleared by a shift, set by a read.
    always_ff @(posedge clk) begin
        if (!rst_n)        xfer_en <= 1'b1;
        else if (do_shift) xfer_en <= 1'b0;
        else if (main_rd)  xfer_en <= 1'b1;
    end

    // Records that the holding register has taken at least one capture.
    always_ff @(posedge clk) begin
        if (!rst_n)       sub_loaded <= 1'b0;
        else if (cap_evt) sub_loaded <= 1'b1;
    end

    // Sticky valid flag, raised by the first shift.
    always_ff @(posedge clk) begin
        if (!rst_n)        main_valid <= 1'b0;
        else if (do_shift) main_valid <= 1'b1;
    end

    // R10: valid never drops without reset.
    p_valid_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        main_valid |=> main_valid);

    // R6: without a read, a second strobe after a shift must not shift.
    p_no_reshift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (do_shift && !main_rd) |=> !(cap_evt && !main_rd && do_shift));

    // R4: the first strobe after reset never shifts.
    p_first_no_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && !sub_loaded) |-> !do_shift);
endmodule

// File: rtl/cap_reg_pair.sv
// Module: cap_reg_pair
// Holding and result capture registers. The holding register takes the
// count on a load. On a shift, the result register takes the old holding
// value in the same edge.
// Assumes: shift is only asserted together with load.
module cap_reg_pair #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic [W-1:0] sub_q,
    output logic [W-1:0] main_q
);
    // Holding register: captures the selected count.
    always_ff @(posedge clk) begin
        if (!rst_n)    sub_q <= '0;
        else if (load) sub_q <= din;
    end

    // Result register: fed only from the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n)     main_q <= '0;
        else if (shift) main_q <= sub_q;
    end

    // R1: a load puts the input count into the holding register.
    p_sub_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> sub_q == $past(din));

    // R1: the holding register is steady when nothing is loaded.
    p_sub_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(sub_q));

    // R3: any change of the result comes from the previous holding value.
    p_main_from_sub_r3: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> main_q == $past(sub_q));

    // R6: without a shift the result register is untouched.
    p_main_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(main_q));
endmodule

// File: rtl/cap_dbuf_channel.sv
// Module: cap_dbuf_channel (top)
// Double-buffered input capture channel: count select, transfer control and
// the holding/result register pair.
// Assumes: cap_evt comes from an edge detector clocked by clk. main_rd
// pulses for one cycle per software read.
module cap_dbuf_channel
    import cap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_a,
    input  logic [CNT_W-1:0] cnt_b,
    input  logic             src_sel,
    input  logic             cap_evt,
    input  logic             main_rd,
    output logic [CNT_W-1:0] main_val,
    output logic [CNT_W-1:0] sub_val,
    output logic             main_valid
);
    logic [CNT_W-1:0] sel_cnt;
    logic             do_load;
    logic             do_shift;

    cap_src_mux #(.W(CNT_W)) u_mux (
        .cnt_a   (cnt_a),
        .cnt_b   (cnt_b),
        .sel     (cap_src_e'(src_sel)),
        .cnt_out (sel_cnt)
    );

    cap_xfer_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_evt    (cap_evt),
        .main_rd    (main_rd),
        .do_load    (do_load),
        .do_shift   (do_shift),
        .main_valid (main_valid)
    );

    cap_reg_pair #(.W(CNT_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (do_load),
        .shift  (do_shift),
        .din    (sel_cnt),
        .sub_q  (sub_val),
        .main_q (main_val)
    );

    // R2: a strobe captures the count named by src_sel.
    p_src_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> sub_val == (($past(src_sel)) ? $past(cnt_b) : $past(cnt_a)));

    // R11: a lone read leaves both registers unchanged.
    p_read_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (main_rd && !cap_evt) |=> ($stable(main_val) && $stable(sub_val)));
endmodule

// File: tb/tb_cap_dbuf_channel.sv
module tb_cap_dbuf_channel;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cnt_a, cnt_b;
    logic        src_sel, cap_evt, main_rd;
    logic [15:0] main_val, sub_val;
    logic        main_valid;
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cap_dbuf_channel dut (
        .clk(clk), .rst_n(rst_n), .cnt_a(cnt_a), .cnt_b(cnt_b),
        .src_sel(src_sel), .cap_evt(cap_evt), .main_rd(main_rd),
        .main_val(main_val), .sub_val(sub_val), .main_valid(main_valid)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge; outputs are sampled at the next one.
    task automatic step(input logic evt, input logic rd, input logic sel,
                        input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        cap_evt = evt; main_rd = rd; src_sel = sel; cnt_a = a; cnt_b = b;
        @(negedge clk);
        cap_evt = 1'b0; main_rd = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0; cap_evt = 0; main_rd = 0; src_sel = 0; cnt_a = 0; cnt_b = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R9 main", main_val, 16'h0);
        chk("R9 sub", sub_val, 16'h0);
        chk("R9 valid", {15'b0, main_valid}, 16'h0);
    endtask

    task automatic t_first;
        step(1, 0, 0, 16'h1111, 16'hAAAA);
        chk("R4 R2 sub", sub_val, 16'h1111);
        chk("R4 main", main_val, 16'h0);
        chk("R4 valid", {15'b0, main_valid}, 16'h0);
        step(0, 0, 1, 16'hBEEF, 16'hCAFE);
        chk("R1 sub hold", sub_val, 16'h1111);
    endtask

    task automatic t_second;
        step(1, 0, 1, 16'h0F0F, 16'h2222);
        chk("R5 R3 main", main_val, 16'h1111);
        chk("R5 R2 sub", sub_val, 16'h2222);
        chk("R10 valid", {15'b0, main_valid}, 16'h1);
    endtask

    task automatic t_hold;
        step(1, 0, 0, 16'h3333, 16'h0);
        chk("R6 main", main_val, 16'h1111);
        chk("R6 sub", sub_val, 16'h3333);
        step(1, 0, 0, 16'h4444, 16'h0);
        chk("R6 main again", main_val, 16'h1111);
        chk("R1 sub", sub_val, 16'h4444);
        chk("R10 valid held", {15'b0, main_valid}, 16'h1);
    endtask

    task automatic t_read;
        step(0, 1, 0, 16'h9999, 16'h9999);
        chk("R11 main", main_val, 16'h1111);
        chk("R11 sub", sub_val, 16'h4444);
        step(1, 0, 0, 16'h5555, 16'h0);
        chk("R7 main", main_val, 16'h4444);
        chk("R7 sub", sub_val, 16'h5555);
    endtask

    task automatic t_same_cycle;
        step(1, 0, 1, 16'h0, 16'h6666);
        chk("R6 main no read", main_val, 16'h4444);
        step(1, 1, 0, 16'h7777, 16'h0);
        chk("R8 main", main_val, 16'h6666);
        chk("R8 sub", sub_val, 16'h7777);
        step(1, 0, 0, 16'h8888, 16'h0);
        chk("R8 disarmed main", main_val, 16'h6666);
        chk("R8 sub", sub_val, 16'h8888);
    endtask

    task automatic t_reset_again;
        t_reset();
        chk("R10 valid cleared by reset", {15'b0, main_valid}, 16'h0);
    endtask

    initial begin
        rst_n = 1'b0; cap_evt = 0; main_rd = 0; src_sel = 0; cnt_a = 0; cnt_b = 0;
        t_reset();
        t_first();
        t_second();
        t_hold();
        t_read();
        t_same_cycle();
        t_reset_again();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule